// File: doc/BRIEF.md
# Byte and Halfword Shuffle Unit

This unit executes the byte-reordering and narrow sign-extension instructions of a 64-bit integer pipeline. It takes the 32-bit instruction word and the 64-bit source operand read from the register file. It returns the 64-bit destination value, a write-enable for the register file and an illegal-instruction flag. All three outputs are registered, one cycle after the inputs.

The unit recognises its own instructions by the major opcode `011111` in bits 31:26 and one of two function codes in bits 5:0. The shift-amount field in bits 10:6 then picks the operation. Under function `100000` it selects the word-size group: byte swap within halfwords (`00010`), sign-extend byte (`10000`) and sign-extend halfword (`11000`). Under function `100100` it selects the doubleword group: byte swap within halfwords (`00010`) and halfword reverse (`00101`). Bits 25:21 must be zero. The doubleword group is legal only while the 64-bit enable input is high. Instruction words outside these two classes are not claimed by the unit.

Top module: `shuf_unit`

## Requirements
- R1: While rst_ni is low, rd_val_o, wr_en_o and illegal_o are all zero, and asserting rst_ni clears them at once without a clock edge.
- R2: Each output reflects the instruction word, operand and enable sampled at the previous rising clock edge.
- R3: With function 100000 and sub-op 00010, the two bytes inside each of the two low halfwords of the operand are exchanged, and bit 31 of that 32-bit result fills bits 63:32.
- R4: With function 100000 and sub-op 10000, bits 7:0 of the operand are sign-extended to 64 bits.
- R5: With function 100000 and sub-op 11000, bits 15:0 of the operand are sign-extended to 64 bits.
- R6: With function 100100, sub-op 00010 and en64_i high, the two bytes inside every one of the four halfwords are exchanged.
- R7: With function 100100, sub-op 00101 and en64_i high, the order of the four halfwords is reversed: bits 63:48 go to 15:0, 15:0 go to 63:48, and 47:32 and 31:16 trade places.
- R8: A claimed word (major opcode 011111, function 100000 or 100100) whose bits 25:21 are nonzero or whose sub-op is not listed above gives illegal_o high, wr_en_o low and rd_val_o zero.
- R9: A doubleword-group word while en64_i is low gives illegal_o high and wr_en_o low. The word-size group is unaffected by en64_i.
- R10: Any word that is not claimed gives illegal_o low, wr_en_o low and rd_val_o zero.
- R11: wr_en_o and illegal_o are never high together, and wr_en_o is high for every legal claimed operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 32 | Instruction word |
| rt_val_i | input | 64 | Source operand value |
| en64_i | input | 1 | Permits the doubleword group |
| rd_val_o | output | 64 | Destination value |
| wr_en_o | output | 1 | Destination write-enable |
| illegal_o | output | 1 | Illegal-instruction flag |

## Verification
The checker watches, on every cycle, that write-enable and the illegal flag stay exclusive and that a suppressed write carries a zero value. It also checks that unclaimed words stay silent, that a doubleword op without the enable traps, and that the byte sign-extension and halfword reversal results match the operand from the previous cycle. The byte-swap patterns and the sign fill from bit 31 in the word swap are shown only by the bench's scenarios. The same holds for the reserved sub-op and nonzero-rs traps, and for the asynchronous clear.

// File: rtl/shuf_pkg.sv
package shuf_pkg;
  typedef enum logic [2:0] {
    OP_NONE,
    OP_WSWAP,
    OP_SXB,
    OP_SXH,
    OP_DSWAP,
    OP_HREV
  } shuf_op_e;

  localparam logic [5:0] MAJOR_OPC = 6'b011111;
  localparam logic [5:0] FN_WORD   = 6'b100000;
  localparam logic [5:0] FN_DWORD  = 6'b100100;
  localparam logic [4:0] SA_WSWAP  = 5'b00010;
  localparam logic [4:0] SA_SXB    = 5'b10000;
  localparam logic [4:0] SA_SXH    = 5'b11000;
  localparam logic [4:0] SA_DSWAP  = 5'b00010;
  localparam logic [4:0] SA_HREV   = 5'b00101;
endpackage

// File: rtl/shuf_decode.sv
module shuf_decode
  import shuf_pkg::*;
(
  input  logic [5:0] opc_i,
  input  logic [4:0] rs_i,
  input  logic [4:0] sa_i,
  input  logic [5:0] fn_i,
  input  logic       en64_i,
  output shuf_op_e   op_o,
  output logic       illegal_o
);
  logic claim;
  logic bad;

  always_comb begin
    claim = (opc_i == MAJOR_OPC) && ((fn_i == FN_WORD) || (fn_i == FN_DWORD));
    op_o  = OP_NONE;
    bad   = 1'b0;
    if (claim) begin
      if (rs_i != 5'd0) begin
        bad = 1'b1;
      end else if (fn_i == FN_WORD) begin
        case (sa_i)
          SA_WSWAP: op_o = OP_WSWAP;
          SA_SXB:   op_o = OP_SXB;
          SA_SXH:   op_o = OP_SXH;
          default:  bad  = 1'b1;
        endcase
      end else if (!en64_i) begin
        bad = 1'b1;
      end else begin
        case (sa_i)
          SA_DSWAP: op_o = OP_DSWAP;
          SA_HREV:  op_o = OP_HREV;
          default:  bad  = 1'b1;
        endcase
      end
    end
    illegal_o = claim && bad;
  end
endmodule

// File: rtl/shuf_datapath.sv
module shuf_datapath
  import shuf_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8
) (
  input  shuf_op_e            op_i,
  input  logic [DATA_W-1:0]   rt_i,
  output logic [DATA_W-1:0]   res_o
);
  localparam int HW_W   = 2 * BYTE_W;
  localparam int NUM_HW = DATA_W / HW_W;

  logic [DATA_W-1:0] bswap;
  logic [DATA_W-1:0] hrev;

  for (genvar g = 0; g < NUM_HW; g++) begin : g_hw
    assign bswap[g*HW_W +: HW_W] = {rt_i[g*HW_W +: BYTE_W], rt_i[g*HW_W+BYTE_W +: BYTE_W]};
    assign hrev[g*HW_W +: HW_W]  = rt_i[(NUM_HW-1-g)*HW_W +: HW_W];
  end

  always_comb begin
    unique case (op_i)
      OP_WSWAP: res_o = {{(DATA_W-WORD_W){bswap[WORD_W-1]}}, bswap[WORD_W-1:0]};
      OP_SXB:   res_o = {{(DATA_W-BYTE_W){rt_i[BYTE_W-1]}}, rt_i[BYTE_W-1:0]};
      OP_SXH:   res_o = {{(DATA_W-HW_W){rt_i[HW_W-1]}}, rt_i[HW_W-1:0]};
      OP_DSWAP: res_o = bswap;
      OP_HREV:  res_o = hrev;
      default:  res_o = '0;
    endcase
  end
endmodule

// File: rtl/shuf_unit.sv
module shuf_unit
  import shuf_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int INSTR_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [DATA_W-1:0]  rt_val_i,
  input  logic               en64_i,
  output logic [DATA_W-1:0]  rd_val_o,
  output logic               wr_en_o,
  output logic               illegal_o
);
  shuf_op_e          op;
  logic              ill_d;
  logic [DATA_W-1:0] res_d;

  // register index fields are routed by the pipeline, not here
  logic unused_fields;
  assign unused_fields = ^instr_i[20:11];

  shuf_decode i_dec (
    .opc_i     (instr_i[31:26]),
    .rs_i      (instr_i[25:21]),
    .sa_i      (instr_i[10:6]),
    .fn_i      (instr_i[5:0]),
    .en64_i    (en64_i),
    .op_o      (op),
    .illegal_o (ill_d)
  );

  shuf_datapath #(.DATA_W(DATA_W)) i_dp (
    .op_i  (op),
    .rt_i  (rt_val_i),
    .res_o (res_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_val_o  <= '0;
      wr_en_o   <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      rd_val_o  <= res_d;
      wr_en_o   <= (op != OP_NONE);
      illegal_o <= ill_d;
    end
  end
endmodule

// File: rtl/shuf_unit_chk.sv
module shuf_unit_chk
  import shuf_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int INSTR_W = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [INSTR_W-1:0] instr_i,
  input logic [DATA_W-1:0]  rt_val_i,
  input logic               en64_i,
  input logic [DATA_W-1:0]  rd_val_o,
  input logic               wr_en_o,
  input logic               illegal_o
);
  logic seen;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen <= 1'b0;
    else         seen <= 1'b1;
  end

  logic is_major, is_dw, is_sxb, is_hrev;
  assign is_major = instr_i[31:26] == MAJOR_OPC;
  assign is_dw    = is_major && instr_i[5:0] == FN_DWORD;
  assign is_sxb   = is_major && instr_i[5:0] == FN_WORD && instr_i[25:21] == 5'd0
                    && instr_i[10:6] == SA_SXB;
  assign is_hrev  = is_dw && en64_i && instr_i[25:21] == 5'd0 && instr_i[10:6] == SA_HREV;

  assert_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_o && illegal_o));

  assert_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_o |-> rd_val_o == '0);

  assert_foreign_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen && !$past(is_major)) |-> (!wr_en_o && !illegal_o));

  assert_en64_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen && $past(is_dw) && !$past(en64_i)) |-> (illegal_o && !wr_en_o));

  assert_sxb_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen && $past(is_sxb)) |->
      (wr_en_o && rd_val_o == {{(DATA_W-8){$past(rt_val_i[7])}}, $past(rt_val_i[7:0])}));

  assert_hrev_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen && $past(is_hrev)) |->
      (wr_en_o && rd_val_o == {$past(rt_val_i[15:0]), $past(rt_val_i[31:16]),
                               $past(rt_val_i[47:32]), $past(rt_val_i[63:48])}));
endmodule

bind shuf_unit shuf_unit_chk #(.DATA_W(DATA_W), .INSTR_W(INSTR_W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .instr_i   (instr_i),
  .rt_val_i  (rt_val_i),
  .en64_i    (en64_i),
  .rd_val_o  (rd_val_o),
  .wr_en_o   (wr_en_o),
  .illegal_o (illegal_o)
);

// File: tb/test_shuf_unit.sv
`timescale 1ns/1ps
module test_shuf_unit;
  localparam logic [5:0] OPC = 6'b011111;
  localparam logic [5:0] FW  = 6'b100000;
  localparam logic [5:0] FD  = 6'b100100;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] instr_i = '0;
  logic [63:0] rt_val_i = '0;
  logic        en64_i = 1'b0;
  logic [63:0] rd_val_o;
  logic        wr_en_o;
  logic        illegal_o;

  always #2.5 clk_i = ~clk_i;

  shuf_unit i_shuf_unit (.*);

  typedef struct {
    logic [63:0] res;
    logic        we;
    logic        ill;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  function automatic logic [31:0] mk(logic [5:0] opc, logic [4:0] rs, logic [4:0] sa, logic [5:0] fn);
    return {opc, rs, 5'd3, 5'd4, sa, fn};
  endfunction

  task automatic cmp(string tag, logic [63:0] r, logic we, logic il, logic [63:0] er, logic ewe, logic eil);
    checks++;
    if (r !== er || we !== ewe || il !== eil) begin
      errors++;
      $display("FAIL %s: got res=%h we=%b ill=%b exp res=%h we=%b ill=%b", tag, r, we, il, er, ewe, eil);
    end
  endtask

  // reference derived from the requirement text
  function automatic exp_t model(logic [31:0] ins, logic [63:0] rt, logic e64, string tag);
    exp_t e;
    logic [31:0] w;
    e.res = '0; e.we = 0; e.ill = 0; e.tag = tag;
    if (ins[31:26] == OPC && (ins[5:0] == FW || ins[5:0] == FD)) begin
      e.ill = 1;
      if (ins[25:21] == 0 && ins[5:0] == FW) begin
        w = {rt[23:16], rt[31:24], rt[7:0], rt[15:8]};
        case (ins[10:6])
          5'b00010: begin e.res = {{32{w[31]}}, w}; e.ill = 0; end
          5'b10000: begin e.res = {{56{rt[7]}}, rt[7:0]}; e.ill = 0; end
          5'b11000: begin e.res = {{48{rt[15]}}, rt[15:0]}; e.ill = 0; end
          default: ;
        endcase
      end else if (ins[25:21] == 0 && e64) begin
        case (ins[10:6])
          5'b00010: begin
            e.res = {rt[55:48], rt[63:56], rt[39:32], rt[47:40], rt[23:16], rt[31:24], rt[7:0], rt[15:8]};
            e.ill = 0;
          end
          5'b00101: begin e.res = {rt[15:0], rt[31:16], rt[47:32], rt[63:48]}; e.ill = 0; end
          default: ;
        endcase
      end
      e.we = !e.ill;
    end
    return e;
  endfunction

  task automatic drive_exp(logic [31:0] ins, logic [63:0] rt, logic e64,
                           logic [63:0] er, logic ewe, logic eil, string tag);
    exp_t e;
    @(negedge clk_i);
    instr_i = ins; rt_val_i = rt; en64_i = e64;
    e.res = er; e.we = ewe; e.ill = eil; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic drive_model(logic [31:0] ins, logic [63:0] rt, logic e64, string tag);
    exp_t e;
    @(negedge clk_i);
    instr_i = ins; rt_val_i = rt; en64_i = e64;
    e = model(ins, rt, e64, tag);
    q.push_back(e);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk_i);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        cmp(e.tag, rd_val_o, wr_en_o, illegal_o, e.res, e.we, e.ill);
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  localparam logic [63:0] V = 64'h0123_4567_89AB_CDEF;

  initial begin
    #1;
    cmp("R1 reset", rd_val_o, wr_en_o, illegal_o, '0, 0, 0);
    @(negedge clk_i);
    instr_i = mk(OPC, 0, 5'b10000, FW); rt_val_i = V;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i); #1;
    cmp("R2 first load", rd_val_o, wr_en_o, illegal_o, 64'hFFFF_FFFF_FFFF_FFEF, 1, 0);
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    cmp("R1 async clear", rd_val_o, wr_en_o, illegal_o, '0, 0, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    drive_exp(mk(OPC, 0, 5'b00010, FW), V, 0, 64'hFFFF_FFFF_AB89_EFCD, 1, 0, "R3 wswap neg");
    drive_exp(mk(OPC, 0, 5'b00010, FW), 64'hFFFF_FFFF_1234_5678, 1, 64'h0000_0000_3412_7856, 1, 0, "R3 wswap pos");
    drive_exp(mk(OPC, 0, 5'b10000, FW), V, 1, 64'hFFFF_FFFF_FFFF_FFEF, 1, 0, "R4 sxb neg");
    drive_exp(mk(OPC, 0, 5'b10000, FW), 64'hFFFF_FFFF_FFFF_FF7F, 0, 64'h7F, 1, 0, "R4 sxb pos");
    drive_exp(mk(OPC, 0, 5'b11000, FW), V, 0, 64'hFFFF_FFFF_FFFF_CDEF, 1, 0, "R5 sxh neg");
    drive_exp(mk(OPC, 0, 5'b11000, FW), 64'h8000_0000_0000_7FFF, 0, 64'h7FFF, 1, 0, "R5 sxh pos");
    drive_exp(mk(OPC, 0, 5'b00010, FD), V, 1, 64'h2301_6745_AB89_EFCD, 1, 0, "R6 dswap");
    drive_exp(mk(OPC, 0, 5'b00101, FD), V, 1, 64'hCDEF_89AB_4567_0123, 1, 0, "R7 hrev");
    drive_exp(mk(OPC, 5'd7, 5'b10000, FW), V, 1, '0, 0, 1, "R8 rs nonzero");
    drive_exp(mk(OPC, 0, 5'b00101, FW), V, 1, '0, 0, 1, "R8 bad word subop");
    drive_exp(mk(OPC, 0, 5'b11000, FD), V, 1, '0, 0, 1, "R8 bad dword subop");
    drive_exp(mk(OPC, 0, 5'b00101, FD), V, 0, '0, 0, 1, "R9 hrev no en64");
    drive_exp(mk(OPC, 0, 5'b00010, FD), V, 0, '0, 0, 1, "R9 dswap no en64");
    drive_exp(mk(OPC, 0, 5'b00010, FW), V, 0, 64'hFFFF_FFFF_AB89_EFCD, 1, 0, "R9 word group without en64");
    drive_exp(mk(6'b000000, 0, 5'b00010, FW), V, 1, '0, 0, 0, "R10 other major");
    drive_exp(mk(OPC, 0, 5'b00010, 6'b100001), V, 1, '0, 0, 0, "R10 other function");
    drive_exp(mk(OPC, 0, 5'b10000, FW), V, 1, 64'hFFFF_FFFF_FFFF_FFEF, 1, 0, "R2 back to back");

    for (int i = 0; i < 400; i++) begin
      logic [5:0] opc, fn;
      logic [4:0] rs, sa;
      logic [63:0] rt;
      int k;
      opc = ($urandom_range(0, 9) == 0) ? 6'($urandom) : OPC;
      k = $urandom_range(0, 4);
      fn = (k < 2) ? FW : (k < 4) ? FD : 6'($urandom);
      rs = ($urandom_range(0, 5) == 0) ? 5'($urandom) : 5'd0;
      k = $urandom_range(0, 5);
      case (k)
        0: sa = 5'b00010;
        1: sa = 5'b10000;
        2: sa = 5'b11000;
        3: sa = 5'b00101;
        default: sa = 5'($urandom);
      endcase
      rt = {$urandom, $urandom};
      drive_model(mk(opc, rs, sa, fn), rt, 1'($urandom), "R11 random mix");
    end

    @(negedge clk_i);
    instr_i = '0;
    repeat (3) @(posedge clk_i);
    #2;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule